// File: doc/BRIEF.md
# Two-Level Rate-Shaping Queue Scheduler

This block picks which packet queue is served next. Queues are grouped under parent nodes, for example logical interfaces under a physical port. Queue `q` belongs to parent `q / (NQ/NP)`. Queues and parents each keep two token buckets. The guarantee bucket tracks the minimum rate and the cap bucket tracks the maximum rate. Bandwidth left over once the guarantees are met is shared between queues in proportion to a per-queue weight.

Software writes rates, burst sizes and weights through a simple register write port. A periodic `tick` refills every bucket. The scheduler offers one grant at a time on a valid/ready output that carries a queue number. When the downstream side accepts a grant it returns the length of the packet it dequeued on `grant_len` in the same cycle. That length is then debited from the queue's buckets and from its parent's buckets.

Back-pressure rules: once `grant_valid` is high it stays high with the same queue number until a cycle where `grant_ready` is high. Buckets and deficits are debited only in that handshake cycle. A new grant can be offered from the cycle after the handshake onward.

Top module: `hqos_sched`

## Requirements
- R1: After reset all buckets are zero and all rates and bursts are zero. No grant is offered, even with every queue backlogged and a refill tick applied.
- R2: A write with `cfg_wr` high targets queue `cfg_addr` when the address is below NQ, and targets parent `cfg_addr-NQ` for addresses NQ to NQ+NP-1. `cfg_fld` selects the field: 0 = guarantee rate, 1 = cap rate, 2 = burst size (shared by both buckets), 3 = weight (queues only, reset value 1).
- R3: Each `tick` adds the configured rate to a bucket, and the result is clipped at the burst size. Each accepted grant subtracts `grant_len` from the granted queue's two buckets and from its parent's two buckets.
- R4: A queue whose cap bucket is zero or negative is never offered.
- R5: Every queue under a parent whose cap bucket is zero or negative is never offered.
- R6: An eligible queue whose guarantee bucket is positive is in the committed class. Committed queues are always offered before any excess-class queue.
- R7: Committed queues are served round-robin in rising queue number, starting after the last committed grant. The start point after reset is queue 0.
- R8: Excess queues are served by deficit round-robin. When no candidate has a positive deficit, every candidate gains weight·2^QSH. A grant debits `grant_len` from the deficit. The pointer stays on the same queue while its deficit remains positive. The deficit of a queue without backlog is zero.
- R9: Among excess queues, those whose parent's guarantee bucket is positive are served first.
- R10: A grant that is offered stays valid with an unchanged queue number until it is accepted.
- R11: Only a queue whose backlog bit is high can be picked. A grant already offered is kept even if its backlog bit falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Refill pulse for all buckets |
| q_backlog | input | NQ | One bit per queue, high when the queue holds a packet |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NQ+NP) | Queue or parent index |
| cfg_fld | input | 2 | Field selector |
| cfg_data | input | RW | Write data |
| grant_valid | output | 1 | A grant is offered |
| grant_ready | input | 1 | Downstream accepts the grant |
| grant_qid | output | $clog2(NQ) | Granted queue |
| grant_len | input | LW | Length of the dequeued packet, sampled at the handshake |

## Verification
The bench keeps the default sizes: eight queues split four and four under two parents, so every queue can be named and the parent of each is known. QSH stays at 6, which makes the quantum 64 bytes. With 64-byte packets the bench can predict the exact deficit round-robin order for a 1:3 weight split. Rates of 1000 with 4000 bursts keep the buckets far from their limits. A small 100/100 cap bucket brings saturation and exhaustion within a handful of ticks and grants.

// File: rtl/hqos_pkg.sv
package hqos_pkg;
  typedef enum logic [1:0] {
    FLD_MIN    = 2'd0,
    FLD_MAX    = 2'd1,
    FLD_BURST  = 2'd2,
    FLD_WEIGHT = 2'd3
  } fld_e;

  typedef enum logic {
    CLS_COMMIT = 1'b0,
    CLS_EXCESS = 1'b1
  } cls_e;
endpackage

// File: rtl/hq_cfg.sv
module hq_cfg #(
  parameter int NQ = 8,
  parameter int NP = 2,
  parameter int RW = 16,
  parameter int WW = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [$clog2(NQ+NP)-1:0]    addr,
  input  logic [1:0]                  fld,
  input  logic [RW-1:0]               data,
  output logic [RW-1:0]               q_min_rate [NQ],
  output logic [RW-1:0]               q_max_rate [NQ],
  output logic [RW-1:0]               q_burst    [NQ],
  output logic [WW-1:0]               q_wt       [NQ],
  output logic [RW-1:0]               p_min_rate [NP],
  output logic [RW-1:0]               p_max_rate [NP],
  output logic [RW-1:0]               p_burst    [NP]
);
  import hqos_pkg::*;
  localparam int AW = $clog2(NQ+NP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        q_min_rate[q] <= '0;
        q_max_rate[q] <= '0;
        q_burst[q]    <= '0;
        q_wt[q]       <= WW'(1);
      end
      for (int p = 0; p < NP; p++) begin
        p_min_rate[p] <= '0;
        p_max_rate[p] <= '0;
        p_burst[p]    <= '0;
      end
    end else if (wr) begin
      for (int q = 0; q < NQ; q++) begin
        if (addr == AW'(q)) begin
          case (fld_e'(fld))
            FLD_MIN:    q_min_rate[q] <= data;
            FLD_MAX:    q_max_rate[q] <= data;
            FLD_BURST:  q_burst[q]    <= data;
            FLD_WEIGHT: q_wt[q]       <= data[WW-1:0];
            default:    ;
          endcase
        end
      end
      for (int p = 0; p < NP; p++) begin
        if (addr == AW'(NQ + p)) begin
          case (fld_e'(fld))
            FLD_MIN:   p_min_rate[p] <= data;
            FLD_MAX:   p_max_rate[p] <= data;
            FLD_BURST: p_burst[p]    <= data;
            default:   ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hq_bucket.sv
module hq_bucket #(
  parameter int RW = 16,
  parameter int CW = 24,
  parameter int LW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [RW-1:0]        rate,
  input  logic [RW-1:0]        burst,
  input  logic                 charge,
  input  logic [LW-1:0]        len,
  output logic signed [CW-1:0] level
);
  localparam int XW = CW + 2;
  localparam logic signed [XW-1:0] FLOOR = {3'b111, {(CW-1){1'b0}}};

  logic signed [XW-1:0] up, nx, burst_x, rate_x, len_x;

  always_comb begin
    burst_x = $signed({{(XW-RW){1'b0}}, burst});
    rate_x  = $signed({{(XW-RW){1'b0}}, rate});
    len_x   = $signed({{(XW-LW){1'b0}}, len});
    up = $signed({{2{level[CW-1]}}, level});
    if (tick) begin
      up = up + rate_x;
      if (up > burst_x) up = burst_x;
    end
    nx = charge ? up - len_x : up;
    if (nx < FLOOR) nx = FLOOR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else        level <= $signed(nx[CW-1:0]);
  end

  // R3
  refill_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !charge) |=> (level <= $signed({1'b0, $past(burst)})));
endmodule

// File: rtl/hq_rr.sv
module hq_rr #(
  parameter int N = 8
) (
  input  logic [N-1:0]         req,
  input  logic [$clog2(N)-1:0] ptr,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  always_comb begin
    int j;
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      j = int'(ptr) + i;
      if (j >= N) j = j - N;
      if (req[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/hqos_sched.sv
module hqos_sched #(
  parameter int NQ  = 8,
  parameter int NP  = 2,
  parameter int RW  = 16,
  parameter int CW  = 24,
  parameter int LW  = 14,
  parameter int WW  = 8,
  parameter int QSH = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [NQ-1:0]            q_backlog,
  input  logic                     cfg_wr,
  input  logic [$clog2(NQ+NP)-1:0] cfg_addr,
  input  logic [1:0]               cfg_fld,
  input  logic [RW-1:0]            cfg_data,
  output logic                     grant_valid,
  input  logic                     grant_ready,
  output logic [$clog2(NQ)-1:0]    grant_qid,
  input  logic [LW-1:0]            grant_len
);
  import hqos_pkg::*;
  localparam int QW  = $clog2(NQ);
  localparam int PW  = $clog2(NP);
  localparam int QPN = NQ / NP;

  logic [RW-1:0] q_min_rate [NQ];
  logic [RW-1:0] q_max_rate [NQ];
  logic [RW-1:0] q_burst    [NQ];
  logic [WW-1:0] q_wt       [NQ];
  logic [RW-1:0] p_min_rate [NP];
  logic [RW-1:0] p_max_rate [NP];
  logic [RW-1:0] p_burst    [NP];

  logic signed [CW-1:0] q_min [NQ];
  logic signed [CW-1:0] q_max [NQ];
  logic signed [CW-1:0] p_min [NP];
  logic signed [CW-1:0] p_max [NP];
  logic signed [CW-1:0] dfc   [NQ];

  logic [NQ-1:0] q_chg, commit_vec, exc_vec, pref_vec, exc_set, dr_req;
  logic [NP-1:0] p_chg, p_open, p_under;
  logic          hs, c_found, x_found, load_g, refill;
  logic [QW-1:0] c_idx, x_idx, rr_c, rr_x, pick_q;
  logic [PW-1:0] grant_par, pick_par;
  cls_e          grant_cls;
  logic signed [CW-1:0] len_s, d_after;

  hq_cfg #(.NQ(NQ), .NP(NP), .RW(RW), .WW(WW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .fld(cfg_fld),
    .data(cfg_data), .q_min_rate(q_min_rate), .q_max_rate(q_max_rate),
    .q_burst(q_burst), .q_wt(q_wt), .p_min_rate(p_min_rate),
    .p_max_rate(p_max_rate), .p_burst(p_burst)
  );

  assign hs        = grant_valid & grant_ready;
  assign grant_par = PW'(int'(grant_qid) / QPN);
  assign len_s     = $signed({{(CW-LW){1'b0}}, grant_len});

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign q_chg[q] = hs && (grant_qid == QW'(q));
    hq_bucket #(.RW(RW), .CW(CW), .LW(LW)) u_min (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rate(q_min_rate[q]),
      .burst(q_burst[q]), .charge(q_chg[q]), .len(grant_len), .level(q_min[q]));
    hq_bucket #(.RW(RW), .CW(CW), .LW(LW)) u_max (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rate(q_max_rate[q]),
      .burst(q_burst[q]), .charge(q_chg[q]), .len(grant_len), .level(q_max[q]));
  end

  for (genvar p = 0; p < NP; p++) begin : g_p
    assign p_chg[p]   = hs && (grant_par == PW'(p));
    assign p_open[p]  = p_max[p] > 0;
    assign p_under[p] = p_min[p] > 0;
    hq_bucket #(.RW(RW), .CW(CW), .LW(LW)) u_min (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rate(p_min_rate[p]),
      .burst(p_burst[p]), .charge(p_chg[p]), .len(grant_len), .level(p_min[p]));
    hq_bucket #(.RW(RW), .CW(CW), .LW(LW)) u_max (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rate(p_max_rate[p]),
      .burst(p_burst[p]), .charge(p_chg[p]), .len(grant_len), .level(p_max[p]));
  end

  // eligibility and class split
  always_comb begin
    logic ok;
    for (int q = 0; q < NQ; q++) begin
      ok            = q_backlog[q] && (q_max[q] > 0) && p_open[q / QPN];
      commit_vec[q] = ok && (q_min[q] > 0);
      exc_vec[q]    = ok && !(q_min[q] > 0);
      pref_vec[q]   = exc_vec[q] && p_under[q / QPN];
    end
    exc_set = (|pref_vec) ? pref_vec : exc_vec;
    for (int q = 0; q < NQ; q++) dr_req[q] = exc_set[q] && (dfc[q] > 0);
  end

  hq_rr #(.N(NQ)) u_rr_commit (.req(commit_vec), .ptr(rr_c), .found(c_found), .idx(c_idx));
  hq_rr #(.N(NQ)) u_rr_excess (.req(dr_req),     .ptr(rr_x), .found(x_found), .idx(x_idx));

  assign load_g   = !grant_valid && (c_found || x_found);
  assign refill   = !grant_valid && !c_found && !x_found && (|exc_set);
  assign pick_q   = c_found ? c_idx : x_idx;
  assign pick_par = PW'(int'(pick_q) / QPN);
  assign d_after  = dfc[grant_qid] - len_s;

  function automatic logic [QW-1:0] wrap_inc(input logic [QW-1:0] v);
    return (v == QW'(NQ - 1)) ? '0 : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_qid   <= '0;
      grant_cls   <= CLS_COMMIT;
      rr_c        <= '0;
      rr_x        <= '0;
    end else if (hs) begin
      grant_valid <= 1'b0;
      if (grant_cls == CLS_EXCESS)
        rr_x <= (d_after > 0) ? grant_qid : wrap_inc(grant_qid);
    end else if (!grant_valid) begin
      if (c_found) begin
        grant_valid <= 1'b1;
        grant_qid   <= c_idx;
        grant_cls   <= CLS_COMMIT;
        rr_c        <= wrap_inc(c_idx);
      end else if (x_found) begin
        grant_valid <= 1'b1;
        grant_qid   <= x_idx;
        grant_cls   <= CLS_EXCESS;
      end
    end
  end

  // deficit counters for weighted excess sharing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) dfc[q] <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (!q_backlog[q])
          dfc[q] <= '0;
        else if (hs && grant_cls == CLS_EXCESS && grant_qid == QW'(q))
          dfc[q] <= dfc[q] - len_s;
        else if (refill && exc_set[q])
          dfc[q] <= dfc[q] + ($signed(CW'(q_wt[q])) <<< QSH);
      end
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=> (grant_valid && $stable(grant_qid) && $stable(grant_cls)));
  // R11
  pick_backlog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_g |-> q_backlog[pick_q]);
  // R4
  pick_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_g |-> (q_max[pick_q] > 0));
  // R5
  pick_parent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_g |-> (p_max[pick_par] > 0));
  // R6
  excess_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant_valid) && grant_cls == CLS_EXCESS) |-> ($past(commit_vec) == '0));
  // R8
  excess_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_g && !c_found) |-> (dfc[x_idx] > 0));
endmodule

// File: tb/sim_hqos_sched.sv
module sim_hqos_sched;
  localparam int NQ = 8;
  localparam int NP = 2;
  localparam int RW = 16;
  localparam int LW = 14;
  localparam int AW = $clog2(NQ+NP);
  localparam int QW = $clog2(NQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [NQ-1:0] q_backlog = '0;
  logic cfg_wr = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [1:0] cfg_fld = '0;
  logic [RW-1:0] cfg_data = '0;
  logic grant_valid;
  logic grant_ready = 1'b0;
  logic [QW-1:0] grant_qid;
  logic [LW-1:0] grant_len = '0;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  hqos_sched #(.NQ(NQ), .NP(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .q_backlog(q_backlog),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_fld(cfg_fld), .cfg_data(cfg_data),
    .grant_valid(grant_valid), .grant_ready(grant_ready),
    .grant_qid(grant_qid), .grant_len(grant_len)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; q_backlog = '0; cfg_wr = 1'b0;
    grant_ready = 1'b0; grant_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int a, input int f, input int d);
    cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_fld = 2'(f); cfg_data = RW'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic setq(input int q, input int mn, input int mx, input int b, input int w);
    cfg(q, 0, mn); cfg(q, 1, mx); cfg(q, 2, b); cfg(q, 3, w);
  endtask

  task automatic setp(input int p, input int mn, input int mx, input int b);
    cfg(NQ + p, 0, mn); cfg(NQ + p, 1, mx); cfg(NQ + p, 2, b);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wait_gv(output bit got);
    got = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (grant_valid) begin
        got = 1'b1;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic grab(input int exp, input int len, input string req);
    bit got;
    wait_gv(got);
    chk(got, req, "grant offered", int'(got), 1);
    if (got) begin
      chk(int'(grant_qid) == exp, req, "granted queue", int'(grant_qid), exp);
      grant_ready = 1'b1; grant_len = LW'(len);
      @(negedge clk);
      grant_ready = 1'b0;
    end
  endtask

  task automatic idle_chk(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      if (grant_valid) seen++;
      @(negedge clk);
    end
    chk(seen == 0, req, "cycles with a grant offered", seen, 0);
  endtask

  // R1: nothing offered out of reset, even after a tick with zero rates
  task automatic t_reset();
    do_reset();
    chk(grant_valid == 1'b0, "R1", "grant_valid after reset", int'(grant_valid), 0);
    q_backlog = '1;
    idle_chk(10, "R1");
    pulse_tick();
    idle_chk(10, "R1");
  endtask

  // R7, R11: committed round-robin over backlogged queues only
  task automatic t_commit_rr();
    do_reset();
    setp(0, 1000, 1000, 4000);
    for (int q = 0; q < 4; q++) setq(q, 1000, 1000, 4000, 1);
    q_backlog = 8'b0000_0111;
    pulse_tick();
    for (int k = 0; k < 6; k++) grab(k % 3, 10, "R7");
  endtask

  // R4, R3, R10, R11: cap exhaustion, refill clipping, hold under back-pressure
  task automatic t_cap_hold();
    bit got;
    int stable;
    do_reset();
    setp(0, 1000, 1000, 4000);
    setq(0, 0, 100, 100, 1);
    q_backlog = 8'b0000_0001;
    pulse_tick();
    grab(0, 150, "R4");
    idle_chk(20, "R4");
    pulse_tick();
    wait_gv(got);
    chk(got, "R3", "grant after refill", int'(got), 1);
    stable = 0;
    pulse_tick();
    pulse_tick();
    q_backlog = '0;
    for (int i = 0; i < 4; i++) begin
      if (grant_valid && grant_qid == '0) stable++;
      @(negedge clk);
    end
    chk(stable == 4, "R10", "cycles holding queue 0", stable, 4);
    chk(grant_valid == 1'b1, "R11", "grant kept after backlog fell", int'(grant_valid), 1);
    q_backlog = 8'b0000_0001;
    grant_ready = 1'b1; grant_len = LW'(100);
    @(negedge clk);
    grant_ready = 1'b0;
    idle_chk(20, "R3");
  endtask

  // R5, R2: parent cap blocks its children, other parent keeps going
  task automatic t_parent_cap();
    do_reset();
    setp(0, 0, 100, 100);
    setp(1, 1000, 1000, 4000);
    setq(0, 1000, 1000, 4000, 1);
    setq(1, 1000, 1000, 4000, 1);
    setq(4, 1000, 1000, 4000, 1);
    q_backlog = 8'b0001_0011;
    pulse_tick();
    grab(0, 100, "R5");
    grab(4, 10, "R5");
    grab(4, 10, "R5");
  endtask

  // R6: committed queue beats a backlogged excess queue
  task automatic t_priority();
    do_reset();
    setp(0, 0, 1000, 4000);
    setp(1, 0, 1000, 4000);
    setq(0, 0, 1000, 4000, 1);
    setq(5, 1000, 1000, 4000, 1);
    q_backlog = 8'b0010_0001;
    pulse_tick();
    for (int k = 0; k < 3; k++) grab(5, 64, "R6");
    q_backlog = 8'b0000_0001;
    grab(0, 64, "R6");
  endtask

  // R8, R2: weights 1 and 3 with 64-byte packets
  task automatic t_drr();
    int exp_seq[8] = '{0, 1, 1, 1, 0, 1, 1, 1};
    do_reset();
    setp(0, 0, 1000, 4000);
    setq(0, 0, 1000, 4000, 1);
    setq(1, 0, 1000, 4000, 3);
    q_backlog = 8'b0000_0011;
    pulse_tick();
    for (int k = 0; k < 8; k++) grab(exp_seq[k], 64, "R8");
  endtask

  // R9: excess queue whose parent is under its guarantee goes first
  task automatic t_pref();
    do_reset();
    setp(0, 0, 1000, 4000);
    setp(1, 1000, 1000, 4000);
    setq(0, 0, 1000, 4000, 1);
    setq(4, 0, 1000, 4000, 1);
    q_backlog = 8'b0001_0001;
    pulse_tick();
    for (int k = 0; k < 3; k++) grab(4, 64, "R9");
    q_backlog = 8'b0000_0001;
    grab(0, 64, "R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_commit_rr();
    t_cap_hold();
    t_parent_cap();
    t_priority();
    t_drr();
    t_pref();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule